// File: doc/BRIEF.md
# Accumulator Partial-Width Rename Tracker

This block models the rename table for a single accumulator register that software can reach through five views: the low byte, the high byte (bits 15:8), and the 16-, 32- and 64-bit widths. The table has only two entries. One entry serves the low byte and the 16-, 32- and 64-bit views, and it records the width of the last value written through them. The other entry serves the high byte. The front end presents one access per cycle, either a read or a write, and gives its view on `req_width`. The codes are 0 low byte, 1 high byte, 2 16-bit, 3 32-bit and 4 64-bit. Codes 5 to 7 are reserved and are treated as 64-bit.

A write takes a fresh physical tag from a free-running counter. The counter starts at 1 after reset, and at reset both entries point at tag 0. A read is renamed to the tags held in the two entries. In some cases neither entry alone holds the full value the read needs. This happens when the read is wider than the recorded width, or when it needs the high byte after that byte was written on its own.

The parameter `STALL_MODE` selects how that case is handled:

- **Merge mode** (`STALL_MODE` = 0): the block spends one cycle injecting a merge operation, and the read is accepted in the following cycle.
- **Stall mode** (`STALL_MODE` = 1): the block holds the front end off for `STALL_CYCLES` cycles (default 3, minimum 2) and injects no merge.

In both modes the two entries end up unified on a new tag at 64-bit width.

The control logic is a two-state machine.

- **RUN**: the block accepts accesses.
- **STALL**: the block counts down a stall. It exists only in stall mode.

The transitions are as follows:

- **RUN→RUN**: a normal access, or a merge injection.
- **RUN→STALL**: a read that needs a merge, in stall mode.
- **STALL→STALL**: the countdown continues.
- **STALL→RUN**: the final stall cycle, which also unifies the entries.

Top module: `acc_rename_tracker`

## Requirements
- R1: After reset, `req_ready` is 1, `merge_inject` is 0, both source tags are 0 and `dst_tag` is 1.
- R2: A 16-, 32- or 64-bit write (codes 2, 3, 4) points both entries at the allocated tag `dst_tag`. A later wide read that needs no merge shows that same tag on both `src_lo_tag` and `src_hi_tag`.
- R3: A low-byte write (code 0) changes only the shared entry (`src_lo_tag`) and records a width of 8 bits.
- R4: A high-byte write (code 1) changes only the high-byte entry (`src_hi_tag`).
- R5: A read of 16, 32 or 64 bits that is wider than the recorded width needs a merge.
- R6: A read of 16, 32 or 64 bits needs a merge when the high byte has been written since the entries were last unified.
- R7: A low-byte or high-byte read never needs a merge, and it is accepted in the same cycle.
- R8: In merge mode, a read that needs a merge drives `merge_inject` = 1 and `req_ready` = 0 for exactly one cycle. In that cycle `src_lo_tag`/`src_hi_tag` give the merge sources and `dst_tag` gives the merge result tag. In the next cycle the read is accepted with both source tags equal to that result.
- R9: The tag counter advances by one for each accepted write and for each merge or unify, and it wraps modulo 2^`TAG_W`.
- R10: In stall mode, a read that needs a merge holds `req_ready` at 0 for `STALL_CYCLES` cycles and never raises `merge_inject`. The read is then accepted with both entries unified on a new tag.
- R11: An accepted read allocates no tag, so `dst_tag` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_width | input | 3 | View code: 0 low byte, 1 high byte, 2 16-bit, 3 32-bit, 4 64-bit |
| req_ready | output | 1 | Access accepted this cycle |
| merge_inject | output | 1 | Merge operation issued this cycle (merge mode only) |
| src_lo_tag | output | TAG_W | Tag held in the shared entry |
| src_hi_tag | output | TAG_W | Tag held in the high-byte entry |
| dst_tag | output | TAG_W | Tag the next write or merge will allocate |

## Verification
The assertions assume the requester keeps a read valid and unchanged until `req_ready` accepts it. This assumption underlies the bound on consecutive not-ready cycles, which is one in merge mode and `STALL_CYCLES` in stall mode. The assertions also assume that only view codes 0 to 4 are presented. The stimulus meets both assumptions: every read that needs a merge is held across the merge or stall cycles before the next access is driven, and the bench uses only the five defined codes. The vector walk covers each view followed by each kind of read, so that both merge causes, the width shortfall and the separately written high byte, occur in sequence.

// File: rtl/acc_rn_pkg.sv
package acc_rn_pkg;

    typedef enum logic [2:0] {
        VIEW_LB  = 3'd0,
        VIEW_HB  = 3'd1,
        VIEW_W16 = 3'd2,
        VIEW_W32 = 3'd3,
        VIEW_W64 = 3'd4
    } acc_view_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_STALL = 1'b1
    } ctl_state_e;

    // width rank of a view as seen from the shared entry: 0=8b,1=16b,2=32b,3=64b
    function automatic logic [1:0] view_rank(input logic [2:0] view);
        logic [1:0] r;
        case (view)
            VIEW_LB, VIEW_HB: r = 2'd0;
            VIEW_W16:         r = 2'd1;
            VIEW_W32:         r = 2'd2;
            default:          r = 2'd3;
        endcase
        return r;
    endfunction

    function automatic logic is_wide(input logic [2:0] view);
        return (view != VIEW_LB) && (view != VIEW_HB);
    endfunction

endpackage

// File: rtl/acc_merge_detect.sv
module acc_merge_detect
    import acc_rn_pkg::*;
(
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [2:0] req_width,
    input  logic [1:0] sh_rank,
    input  logic       hi_split,
    output logic       need_merge
);

    logic wide_read;
    logic short_width;

    always_comb begin
        wide_read   = req_valid && !req_write && is_wide(req_width);
        short_width = view_rank(req_width) > sh_rank;
        need_merge  = wide_read && (short_width || hi_split);
    end

endmodule

// File: rtl/acc_tag_counter.sv
module acc_tag_counter #(
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    output logic [TAG_W-1:0] next_tag
);

    localparam logic [TAG_W-1:0] FIRST_TAG = TAG_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_tag <= FIRST_TAG;
        end else if (alloc) begin
            next_tag <= next_tag + TAG_W'(1);
        end
    end

endmodule

// File: rtl/acc_rename_table.sv
module acc_rename_table
    import acc_rn_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_view,
    input  logic             unify,
    input  logic [TAG_W-1:0] new_tag,
    output logic [TAG_W-1:0] sh_tag,
    output logic [1:0]       sh_rank,
    output logic [TAG_W-1:0] hi_tag,
    output logic             hi_split
);

    localparam logic [1:0] RANK_FULL = 2'd3;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_tag   <= '0;
            hi_tag   <= '0;
            sh_rank  <= RANK_FULL;
            hi_split <= 1'b0;
        end else if (unify) begin
            sh_tag   <= new_tag;
            hi_tag   <= new_tag;
            sh_rank  <= RANK_FULL;
            hi_split <= 1'b0;
        end else if (wr_en) begin
            case (wr_view)
                VIEW_LB: begin
                    sh_tag  <= new_tag;
                    sh_rank <= 2'd0;
                end
                VIEW_HB: begin
                    hi_tag   <= new_tag;
                    hi_split <= 1'b1;
                end
                default: begin
                    sh_tag   <= new_tag;
                    hi_tag   <= new_tag;
                    sh_rank  <= view_rank(wr_view);
                    hi_split <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/acc_rename_tracker.sv
module acc_rename_tracker
    import acc_rn_pkg::*;
#(
    parameter int TAG_W        = 6,
    parameter bit STALL_MODE   = 1'b0,
    parameter int STALL_CYCLES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [2:0]       req_width,
    output logic             req_ready,
    output logic             merge_inject,
    output logic [TAG_W-1:0] src_lo_tag,
    output logic [TAG_W-1:0] src_hi_tag,
    output logic [TAG_W-1:0] dst_tag
);

    localparam int              CNT_W     = $clog2(STALL_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STALL_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    ctl_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    logic             need_merge;
    logic             inject_ok;
    logic             unify;
    logic             wr_en;
    logic             alloc;
    logic [1:0]       sh_rank;
    logic             hi_split;
    logic [TAG_W-1:0] next_tag;

    generate
        if (STALL_MODE) begin : g_stall_variant
            assign inject_ok = 1'b0;
        end else begin : g_merge_variant
            assign inject_ok = 1'b1;
        end
    endgenerate

    acc_merge_detect u_detect (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_width (req_width),
        .sh_rank   (sh_rank),
        .hi_split  (hi_split),
        .need_merge(need_merge)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (need_merge && !inject_ok) begin
                    state_d = ST_STALL;
                    cnt_d   = CNT_LOAD;
                end
            end
            ST_STALL: begin
                if (cnt_q == CNT_LAST) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        req_ready    = 1'b0;
        merge_inject = 1'b0;
        unify        = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                req_ready    = !need_merge;
                merge_inject = need_merge && inject_ok;
                unify        = need_merge && inject_ok;
            end
            ST_STALL: begin
                unify = (cnt_q == CNT_LAST);
            end
        endcase
        wr_en = req_valid && req_ready && req_write;
        alloc = wr_en || unify;
    end

    acc_tag_counter #(.TAG_W(TAG_W)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .alloc   (alloc),
        .next_tag(next_tag)
    );

    acc_rename_table #(.TAG_W(TAG_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_view (req_width),
        .unify   (unify),
        .new_tag (next_tag),
        .sh_tag  (src_lo_tag),
        .sh_rank (sh_rank),
        .hi_tag  (src_hi_tag),
        .hi_split(hi_split)
    );

    assign dst_tag = next_tag;

endmodule

// File: rtl/acc_rename_tracker_chk.sv
module acc_rename_tracker_chk #(
    parameter int TAG_W        = 6,
    parameter bit STALL_MODE   = 1'b0,
    parameter int STALL_CYCLES = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [2:0]       req_width,
    input logic             req_ready,
    input logic             merge_inject,
    input logic [TAG_W-1:0] src_lo_tag,
    input logic [TAG_W-1:0] src_hi_tag,
    input logic [TAG_W-1:0] dst_tag
);

    localparam int WAIT_LIMIT = STALL_MODE ? STALL_CYCLES : 1;

    logic [15:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (req_valid && !req_ready) begin
            if (wait_cnt != 16'hFFFF) wait_cnt <= wait_cnt + 16'd1;
        end else begin
            wait_cnt <= '0;
        end
    end

    // R8: a merge cycle accepts nothing
    a_r8_merge_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        merge_inject |-> !req_ready);

    // R8: a merge never repeats in the next cycle
    a_r8_merge_single: assert property (@(posedge clk) disable iff (!rst_n)
        merge_inject |=> !merge_inject);

    // R9: an accepted write moves the tag counter by one
    a_r9_write_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> (dst_tag == $past(dst_tag) + TAG_W'(1)));

    // R11: an accepted read allocates nothing
    a_r11_read_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> $stable(dst_tag));

    // R2: an accepted wide read always sees both entries on one tag
    a_r2_wide_read_unified: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write && req_width >= 3'd2) |->
            (src_lo_tag == src_hi_tag));

    // R10: a held request waits no longer than the mode allows
    a_r10_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= 16'(WAIT_LIMIT));

    generate
        if (STALL_MODE) begin : g_stall_chk
            // R10: stall mode never injects a merge
            a_r10_no_inject: assert property (@(posedge clk) disable iff (!rst_n)
                !merge_inject);
        end
    endgenerate

endmodule

bind acc_rename_tracker acc_rename_tracker_chk #(
    .TAG_W       (TAG_W),
    .STALL_MODE  (STALL_MODE),
    .STALL_CYCLES(STALL_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_width   (req_width),
    .req_ready   (req_ready),
    .merge_inject(merge_inject),
    .src_lo_tag  (src_lo_tag),
    .src_hi_tag  (src_hi_tag),
    .dst_tag     (dst_tag)
);

// File: tb/acc_rename_tracker_tb.sv
module acc_rename_tracker_tb;

    localparam int TAG_W = 6;
    localparam int NVEC  = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic             m_valid = 1'b0, m_write = 1'b0;
    logic [2:0]       m_width = 3'd0;
    logic             m_ready, m_inject;
    logic [TAG_W-1:0] m_lo, m_hi, m_dst;

    logic             s_valid = 1'b0, s_write = 1'b0;
    logic [2:0]       s_width = 3'd0;
    logic             s_ready, s_inject;
    logic [TAG_W-1:0] s_lo, s_hi, s_dst;

    acc_rename_tracker #(.TAG_W(TAG_W), .STALL_MODE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(m_valid), .req_write(m_write),
        .req_width(m_width), .req_ready(m_ready), .merge_inject(m_inject),
        .src_lo_tag(m_lo), .src_hi_tag(m_hi), .dst_tag(m_dst));

    acc_rename_tracker #(.TAG_W(TAG_W), .STALL_MODE(1'b1), .STALL_CYCLES(3)) u_dut_stall (
        .clk(clk), .rst_n(rst_n), .req_valid(s_valid), .req_write(s_write),
        .req_width(s_width), .req_ready(s_ready), .merge_inject(s_inject),
        .src_lo_tag(s_lo), .src_hi_tag(s_hi), .dst_tag(s_dst));

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    // {write, view, merge, lo, hi, dst}
    localparam logic [22:0] VECS [0:NVEC-1] = '{
        {1'b0, 3'd4, 1'b0, 6'd0, 6'd0, 6'd1},
        {1'b1, 3'd3, 1'b0, 6'd0, 6'd0, 6'd1},
        {1'b0, 3'd4, 1'b1, 6'd1, 6'd1, 6'd2},
        {1'b1, 3'd1, 1'b0, 6'd0, 6'd0, 6'd3},
        {1'b0, 3'd0, 1'b0, 6'd2, 6'd3, 6'd4},
        {1'b0, 3'd1, 1'b0, 6'd2, 6'd3, 6'd4},
        {1'b0, 3'd2, 1'b1, 6'd2, 6'd3, 6'd4},
        {1'b1, 3'd0, 1'b0, 6'd0, 6'd0, 6'd5},
        {1'b0, 3'd1, 1'b0, 6'd5, 6'd4, 6'd6},
        {1'b0, 3'd3, 1'b1, 6'd5, 6'd4, 6'd6},
        {1'b1, 3'd2, 1'b0, 6'd0, 6'd0, 6'd7},
        {1'b0, 3'd2, 1'b0, 6'd7, 6'd7, 6'd8},
        {1'b0, 3'd3, 1'b1, 6'd7, 6'd7, 6'd8},
        {1'b1, 3'd4, 1'b0, 6'd0, 6'd0, 6'd9},
        {1'b0, 3'd3, 1'b0, 6'd9, 6'd9, 6'd10}
    };

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #5;
        eq("R1 ready", int'(m_ready), 1);
        eq("R1 inject", int'(m_inject), 0);
        eq("R1 lo tag", int'(m_lo), 0);
        eq("R1 hi tag", int'(m_hi), 0);
        eq("R1 dst tag", int'(m_dst), 1);
        eq("R1 stall-mode dst", int'(s_dst), 1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
        end
    end

    initial begin
        do_reset();

        // vector walk on the merge-mode instance
        for (int i = 0; i < NVEC; i++) begin
            logic       wr, mg;
            logic [2:0] vw;
            int lo, hi, d;
            string wtag, rtag, mtag;
            wr = VECS[i][22];
            vw = VECS[i][21:19];
            mg = VECS[i][18];
            lo = int'(VECS[i][17:12]);
            hi = int'(VECS[i][11:6]);
            d  = int'(VECS[i][5:0]);
            wtag = (vw == 3'd0) ? "R3" : (vw == 3'd1) ? "R4" : "R2";
            rtag = (vw <= 3'd1) ? "R7" : "R2";
            mtag = (i == 6) ? "R6" : "R5";
            @(negedge clk);
            m_valid = 1'b1; m_write = wr; m_width = vw;
            #5;
            if (wr) begin
                eq({wtag, " write ready"}, int'(m_ready), 1);
                eq({wtag, " write tag / R9"}, int'(m_dst), d);
            end else if (!mg) begin
                eq({rtag, " read ready"}, int'(m_ready), 1);
                eq({rtag, " read no merge"}, int'(m_inject), 0);
                eq({rtag, " read lo tag"}, int'(m_lo), lo);
                eq({rtag, " read hi tag"}, int'(m_hi), hi);
                eq("R11 read keeps dst", int'(m_dst), d);
            end else begin
                eq({mtag, " merge inject"}, int'(m_inject), 1);
                eq("R8 merge not ready", int'(m_ready), 0);
                eq("R8 merge src lo", int'(m_lo), lo);
                eq("R8 merge src hi", int'(m_hi), hi);
                eq("R8 merge dst / R9", int'(m_dst), d);
                @(negedge clk);
                #5;
                eq("R8 accept ready", int'(m_ready), 1);
                eq("R8 accept no inject", int'(m_inject), 0);
                eq("R8 accept lo", int'(m_lo), d);
                eq("R8 accept hi", int'(m_hi), d);
            end
            if (wr) begin
                // entry effect of the write, visible next cycle
                @(negedge clk);
                m_valid = 1'b0;
                #5;
                if (vw == 3'd1) begin
                    eq("R4 hi entry updated", int'(m_hi), d);
                    eq("R4 shared entry kept", int'(m_lo), (d == 3) ? 2 : -1);
                end else if (vw == 3'd0) begin
                    eq("R3 shared entry updated", int'(m_lo), d);
                    eq("R3 hi entry kept", int'(m_hi), 4);
                end else begin
                    eq("R2 shared entry", int'(m_lo), d);
                    eq("R2 hi entry", int'(m_hi), d);
                end
            end
        end
        @(negedge clk);
        m_valid = 1'b0;

        // counter wrap: tags 10..63 consumed, next is 0
        for (int k = 0; k < 54; k++) begin
            @(negedge clk);
            m_valid = 1'b1; m_write = 1'b1; m_width = 3'd4;
        end
        @(negedge clk);
        m_valid = 1'b0;
        #5;
        eq("R9 wrap to zero", int'(m_dst), 0);
        eq("R2 last write tag", int'(m_lo), 63);
        @(negedge clk);
        m_valid = 1'b1; m_write = 1'b1; m_width = 3'd4;
        @(negedge clk);
        m_valid = 1'b0;
        #5;
        eq("R9 after wrap", int'(m_dst), 1);

        // reset mid-run
        do_reset();

        // stall-mode instance
        @(negedge clk);
        s_valid = 1'b1; s_write = 1'b1; s_width = 3'd3;
        #5;
        eq("R2 stall-mode write tag", int'(s_dst), 1);
        @(negedge clk);
        s_write = 1'b0; s_width = 3'd4;
        begin
            int waits = 0;
            int injects = 0;
            for (int c = 0; c < 20; c++) begin
                #5;
                if (s_inject) injects++;
                if (s_ready) break;
                waits++;
                @(negedge clk);
            end
            eq("R10 stall cycles", waits, 3);
            eq("R10 no inject", injects, 0);
            eq("R10 unified lo", int'(s_lo), 2);
            eq("R10 unified hi", int'(s_hi), 2);
        end
        @(negedge clk);
        s_valid = 1'b0;
        #5;
        eq("R11 stall-mode read keeps dst", int'(s_dst), 3);

        done = 1'b1;
        summary();
    end

endmodule